// File: doc/BRIEF.md
# Queued Pulse Delay and Stretcher

This block turns each rising edge on a one-bit trigger line into a single output pulse. The pulse starts a programmable number of clock ticks after the trigger, and it lasts a programmable number of ticks. The length of the trigger's high level has no effect on it. The block keeps a free-running tick counter. For every accepted trigger it stores the absolute tick at which the pulse must begin in a small first-in first-out queue. Because of this, the delay may be much longer than the spacing between triggers, and the pending pulses still come out in order, each one after its own delay.

The block never stretches two pulses into one. A new trigger is rejected if its pulse would start before the previous accepted pulse had ended and been low for at least one tick. A trigger is also rejected when the queue is full. A queued pulse is discarded if the output is still high when its start tick arrives, which can happen after the width setting has been raised. Every rejection or discard adds to a status counter. A second status output gives the number of pulses waiting in the queue. Deasserting the enable, or pulsing the synchronous flush input, empties the queue, drives the output low and clears both status values.

The delay and width settings are meant to stay constant while pulses are queued. Change them only while the block is disabled or idle.

Top module: `pulse_queue_delay`

## Requirements
- R1: Suppose the trigger is low at one rising clock edge and high at the next one, edge n. The output is then high in the cycles after edges n+D through n+D+W-1, where D is `delay_cfg` and W is `width_cfg`. A D of 0 acts as 1.
- R2: The output pulse lasts exactly W cycles, whatever the length of the trigger's high level. A trigger held high produces one pulse only.
- R3: A W of 0 acts as 1, so the pulse is one cycle long.
- R4: When D is larger than the trigger spacing, every accepted trigger is still emitted, in arrival order, each at its own start tick.
- R5: `queued_cnt` equals the number of accepted pulses whose start edge has not yet been reached. It drops by one at the edge where a pulse starts.
- R6: Let s_new be the start tick of a new trigger and s_last the start tick of the last accepted pulse. If s_new minus s_last is at most W, the new trigger is discarded and `dropped_cnt` goes up by one.
- R7: If the queue already holds DEPTH (default 16) pending pulses at the edge where a trigger is sampled, that trigger is discarded and `dropped_cnt` goes up by one.
- R8: If `pulse_out` is high at the edge where a queued start tick is reached, that queued pulse is discarded, the running pulse continues unchanged, and `dropped_cnt` goes up by one.
- R9: After any clock edge where `enable` is low or `flush` is high, `pulse_out` is 0, `queued_cnt` is 0 and `dropped_cnt` is 0. Triggers seen while disabled are ignored.
- R10: After `rst_n` is asserted, `pulse_out`, `queued_cnt` and `dropped_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all ticks are counted on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; when low the block is held cleared |
| flush | input | 1 | Synchronous clear of queue, output and counters |
| trig_in | input | 1 | Trigger; a rising edge requests one pulse |
| delay_cfg | input | 32 | Delay from trigger edge to pulse start, in ticks |
| width_cfg | input | 32 | Output pulse length, in ticks |
| pulse_out | output | 1 | Delayed, fixed-width output pulse |
| queued_cnt | output | 5 | Number of pulses waiting to start |
| dropped_cnt | output | 16 | Count of discarded pulses since the last clear (wraps) |

## Verification
A trigger sampled at edge n must raise the output after edge n+D. The output must fall after edge n+D+W. The queue count grows right after edge n and shrinks right after edge n+D. The drop counter moves after the edge where the trigger is sampled (R6, R7), or after the edge of the start tick (R8). The bench drives its inputs on falling edges and samples on falling edges, so each expected value is tied to a counted edge index. For each accepted trigger, the driver computes the high window from these rules and queues it. Every cycle, the monitor compares the output against the window at the head of that queue.

// File: rtl/pqd_pkg.sv
package pqd_pkg;

  localparam int CFG_W = 32;

  // Settings of zero are promoted to one tick.
  function automatic logic [CFG_W-1:0] min_one(input logic [CFG_W-1:0] v);
    return (v == '0) ? {{(CFG_W-1){1'b0}}, 1'b1} : v;
  endfunction

endpackage

// File: rtl/pqd_ts_fifo.sv
module pqd_ts_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = wrap_inc(wr_q);
      if (pop_ok)  rd_d = wrap_inc(rd_q);
      if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
      else if (!push_ok && pop_ok) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q] <= din;
  end

endmodule

// File: rtl/pqd_admit.sv
module pqd_admit
  import pqd_pkg::*;
(
  input  logic             rise,
  input  logic             full,
  input  logic             have_last,
  input  logic [CFG_W-1:0] now,
  input  logic [CFG_W-1:0] last_start,
  input  logic [CFG_W-1:0] delay_cfg,
  input  logic [CFG_W-1:0] width_cfg,
  output logic [CFG_W-1:0] start_t,
  output logic             accept,
  output logic             reject
);

  logic [CFG_W-1:0] gap;
  logic             overlap;

  assign start_t = now + min_one(delay_cfg);
  assign gap     = start_t - last_start;
  // At least one low tick must separate consecutive pulses.
  assign overlap = have_last && (gap <= min_one(width_cfg));
  assign accept  = rise && !full && !overlap;
  assign reject  = rise && (full || overlap);

endmodule

// File: rtl/pqd_pulse_gen.sv
module pqd_pulse_gen
  import pqd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CFG_W-1:0] now,
  input  logic [CFG_W-1:0] head_t,
  input  logic             head_vld,
  input  logic [CFG_W-1:0] width_cfg,
  output logic             pulse,
  output logic             pop,
  output logic             late_drop
);

  logic             pulse_q, pulse_d;
  logic [CFG_W-1:0] end_q, end_d;
  logic             hit;

  assign hit       = head_vld && !clr && (head_t == now);
  assign pop       = hit;
  assign late_drop = hit && pulse_q;
  assign pulse     = pulse_q;

  always_comb begin
    pulse_d = pulse_q;
    end_d   = end_q;
    if (clr) begin
      pulse_d = 1'b0;
    end else if (hit && !pulse_q) begin
      pulse_d = 1'b1;
      end_d   = now + min_one(width_cfg);
    end else if (pulse_q && (now == end_q)) begin
      pulse_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      end_q   <= '0;
    end else begin
      pulse_q <= pulse_d;
      end_q   <= end_d;
    end
  end

endmodule

// File: rtl/pulse_queue_delay.sv
module pulse_queue_delay
  import pqd_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DROP_W = 16,
  localparam int QC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              flush,
  input  logic              trig_in,
  input  logic [CFG_W-1:0]  delay_cfg,
  input  logic [CFG_W-1:0]  width_cfg,
  output logic              pulse_out,
  output logic [QC_W-1:0]   queued_cnt,
  output logic [DROP_W-1:0] dropped_cnt
);

  logic              clr, rise;
  logic              trig_q;
  logic [CFG_W-1:0]  now_q, now_d;
  logic [CFG_W-1:0]  last_q, last_d;
  logic              have_q, have_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic [CFG_W-1:0]  start_t, head_t;
  logic              accept, reject, full, empty, pop, late_drop;

  assign clr  = flush || !enable;
  assign rise = trig_in && !trig_q && !clr;

  pqd_admit u_admit (
    .rise       (rise),
    .full       (full),
    .have_last  (have_q),
    .now        (now_q),
    .last_start (last_q),
    .delay_cfg  (delay_cfg),
    .width_cfg  (width_cfg),
    .start_t    (start_t),
    .accept     (accept),
    .reject     (reject)
  );

  pqd_ts_fifo #(.W(CFG_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .push  (accept),
    .din   (start_t),
    .pop   (pop),
    .dout  (head_t),
    .count (queued_cnt),
    .full  (full),
    .empty (empty)
  );

  pqd_pulse_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .now       (now_q),
    .head_t    (head_t),
    .head_vld  (!empty),
    .width_cfg (width_cfg),
    .pulse     (pulse_out),
    .pop       (pop),
    .late_drop (late_drop)
  );

  always_comb begin
    now_d  = now_q + 1'b1;
    last_d = last_q;
    have_d = have_q;
    drop_d = drop_q;
    if (clr) begin
      have_d = 1'b0;
      drop_d = '0;
    end else begin
      if (accept) begin
        last_d = start_t;
        have_d = 1'b1;
      end
      drop_d = drop_q + {{(DROP_W-1){1'b0}}, reject}
                      + {{(DROP_W-1){1'b0}}, late_drop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      now_q  <= '0;
      last_q <= '0;
      have_q <= 1'b0;
      drop_q <= '0;
    end else begin
      trig_q <= trig_in;
      now_q  <= now_d;
      last_q <= last_d;
      have_q <= have_d;
      drop_q <= drop_d;
    end
  end

  assign dropped_cnt = drop_q;

endmodule

// File: rtl/pulse_queue_delay_chk.sv
module pulse_queue_delay_chk #(
  parameter int DEPTH  = 16,
  parameter int QC_W   = 5,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              flush,
  input logic              pulse_out,
  input logic [QC_W-1:0]   queued_cnt,
  input logic [DROP_W-1:0] dropped_cnt
);

  // R7
  qcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    queued_cnt <= QC_W'(DEPTH));

  // R5
  start_from_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> ($past(queued_cnt) != '0));

  // R9
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || flush) |=> (!pulse_out && queued_cnt == '0 && dropped_cnt == '0));

  // R6
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !flush) |=> (DROP_W'(dropped_cnt - $past(dropped_cnt)) <= DROP_W'(2)));

  // R5
  qcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !flush) |=> (queued_cnt == $past(queued_cnt) ||
                            queued_cnt == $past(queued_cnt) + 1'b1 ||
                            queued_cnt == $past(queued_cnt) - 1'b1));

endmodule

bind pulse_queue_delay pulse_queue_delay_chk #(
  .DEPTH(DEPTH), .QC_W(QC_W), .DROP_W(DROP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .flush       (flush),
  .pulse_out   (pulse_out),
  .queued_cnt  (queued_cnt),
  .dropped_cnt (dropped_cnt)
);

// File: tb/pulse_queue_delay_tb.sv
module pulse_queue_delay_tb;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n, enable, flush, trig_in;
  logic [31:0] delay_cfg, width_cfg;
  logic        pulse_out;
  logic [4:0]  queued_cnt;
  logic [15:0] dropped_cnt;

  always #2 clk = ~clk;

  pulse_queue_delay u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush),
    .trig_in(trig_in), .delay_cfg(delay_cfg), .width_cfg(width_cfg),
    .pulse_out(pulse_out), .queued_cnt(queued_cnt), .dropped_cnt(dropped_cnt)
  );

  typedef struct { int s; int e; } win_t;
  win_t sb[$];
  int   starts[$];
  int   cyc = 0;
  int   errors = 0, checks = 0, exp_drop = 0, last_s = 0;
  bit   have_last = 0, mon_on = 0, fall_due = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pend_now();
    int n = 0;
    foreach (starts[i]) if (starts[i] > cyc) n++;
    return n;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raw_trig(int hi, int lo);
    trig_in = 1'b1;
    repeat (hi) @(negedge clk);
    trig_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  // Driver: predicts acceptance and pushes the expected high window.
  task automatic fire(int hi, int lo);
    int n0, s, ew, pend;
    n0 = cyc + 1;
    s  = n0 + ((delay_cfg == 0) ? 1 : int'(delay_cfg));
    ew = (width_cfg == 0) ? 1 : int'(width_cfg);
    pend = 0;
    foreach (starts[i]) if (starts[i] >= n0) pend++;
    if (pend >= DEPTH) exp_drop++;
    else if (have_last && (s - last_s) <= ew) exp_drop++;
    else begin
      starts.push_back(s);
      last_s = s;
      have_last = 1;
      sb.push_back('{s, s + ew - 1});
    end
    raw_trig(hi, lo);
  endtask

  // Monitor: compares pulse_out with the window at the scoreboard head.
  always @(negedge clk) begin
    if (mon_on) begin
      bit exp_hi;
      exp_hi = (sb.size() > 0) && (cyc >= sb[0].s) && (cyc <= sb[0].e);
      if (fall_due) begin
        chk("R2 pulse end", pulse_out, 0);
        fall_due = 0;
      end else if (sb.size() > 0 && cyc == sb[0].s) begin
        chk("R1 pulse start", pulse_out, 1);
      end else if (pulse_out !== exp_hi) begin
        chk("R1 pulse level", pulse_out, exp_hi);
      end
      if (sb.size() > 0 && cyc == sb[0].e) begin
        void'(sb.pop_front());
        fall_due = 1;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n1, n2;
    rst_n = 0; enable = 1; flush = 0; trig_in = 0;
    delay_cfg = 10; width_cfg = 3;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 pulse_out", pulse_out, 0);
    chk("R10 queued_cnt", queued_cnt, 0);
    chk("R10 dropped_cnt", dropped_cnt, 0);
    mon_on = 1;

    // R1 single trigger
    fire(1, 20);
    idle(5);
    // R2 long trigger level, fixed width
    fire(7, 20);
    // R3 width of zero acts as one
    width_cfg = 0;
    fire(1, 15);
    // R1 delay of zero acts as one
    delay_cfg = 0; width_cfg = 2;
    fire(1, 10);

    // R4 / R5 several pending pulses, delay longer than spacing
    delay_cfg = 30; width_cfg = 2;
    repeat (5) fire(1, 3);
    chk("R5 queued after burst", queued_cnt, pend_now());
    chk("R4 five pending", queued_cnt, 5);
    idle(40);
    chk("R4 queue drained", queued_cnt, 0);

    // R6 overlap rejection
    delay_cfg = 10; width_cfg = 5;
    repeat (4) fire(1, 3);
    idle(25);
    chk("R6 dropped_cnt", dropped_cnt, exp_drop);

    // R7 full queue rejection
    delay_cfg = 200; width_cfg = 1;
    repeat (20) fire(1, 2);
    chk("R7 queue full", queued_cnt, DEPTH);
    chk("R7 dropped_cnt", dropped_cnt, exp_drop);
    idle(220);

    // R8 output still high at a queued start
    delay_cfg = 20; width_cfg = 2;
    n1 = cyc + 1;
    raw_trig(1, 4);
    n2 = cyc + 1;
    raw_trig(1, 1);
    width_cfg = 12;
    sb.push_back('{n1 + 20, n1 + 31});
    starts.push_back(n1 + 20);
    starts.push_back(n2 + 20);
    have_last = 1; last_s = n2 + 20;
    exp_drop++;
    idle(40);
    chk("R8 dropped_cnt", dropped_cnt, exp_drop);
    width_cfg = 2;

    // R9 flush clears queue and counters
    delay_cfg = 50;
    repeat (3) fire(1, 3);
    chk("R5 queued before flush", queued_cnt, 3);
    flush = 1;
    @(negedge clk);
    flush = 0;
    sb.delete(); starts.delete(); have_last = 0; exp_drop = 0;
    chk("R9 flush queued_cnt", queued_cnt, 0);
    chk("R9 flush dropped_cnt", dropped_cnt, 0);
    chk("R9 flush pulse_out", pulse_out, 0);

    // R9 triggers ignored while disabled
    enable = 0;
    repeat (3) raw_trig(1, 3);
    chk("R9 disabled queued_cnt", queued_cnt, 0);
    chk("R9 disabled dropped_cnt", dropped_cnt, 0);
    idle(60);
    enable = 1;
    @(negedge clk);
    delay_cfg = 6; width_cfg = 4;
    fire(1, 15);
    chk("R9 re-enabled dropped_cnt", dropped_cnt, exp_drop);

    mon_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule